// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns simple internal memory requests into external bus cycles on a shared address/data bus. A request carries an address, a read/write flag, an instruction-fetch flag, a byte/word size and write data. The controller drives the address on the shared bus and marks it with an address strobe. It then runs the data phase with read or write strobes, and returns read data together with a one-clock completion pulse. One clock of the block is one oscillator period, and two clocks form one state time.

The width of each bus cycle can come from a pin that the external memory decoder samples, or can be fixed at 8 bits. A word request that meets an 8-bit cycle is carried out as two byte cycles. Wait states can be inserted by an external READY input, by a programmed internal count, or by both. Two configuration bits choose the strobe styles. The address strobe is either a one-clock latch pulse or an active-low address-valid level. The write strobes are either "write plus high-byte enable" or "write low lane plus write high lane".

The requester holds its request fields stable from the clock it raises `req_valid` until it sees `req_done`, and drops `req_valid` in that same clock. Configuration inputs are changed only while no request is pending.

Top module: `xbus_ctrl`

## Requirements
- R1: With no request in progress, `rd_n`, `wr_lo_n` and `wr_hi_n` are high, `ad_oe` and `inst_o` are low, and `addr_stb` sits at its idle level (low in pulse style, high in level style). Toggling `ready_i` or `bus_width_i` changes none of these outputs and produces no `req_done`.
- R2: A cycle with no wait states lasts 4 clocks. Clock 1 is the address phase: the cycle address is on `ad_o` with `ad_oe` high. `req_done` is high in clock 4.
- R3: When `cfg_dyn_width` is 1, `bus_width_i` is sampled at the end of the address phase: 1 selects a 16-bit cycle and 0 selects an 8-bit cycle. When `cfg_dyn_width` is 0, every cycle is 8-bit. A word request on a 16-bit cycle completes in one cycle with `req_rdata` equal to `ad_i`.
- R4: A word request, which must have an even address, that meets an 8-bit cycle runs as two back-to-back cycles (8 clocks). The first uses the request address and the low byte. The second uses the address plus one and the high byte. A read assembles the first byte into `req_rdata[7:0]` and the second into `req_rdata[15:8]`.
- R5: `ready_i` is sampled at the end of the second clock of a cycle. If it is low, wait states of 2 clocks each are inserted. The cycle leaves the wait only at the end of a wait state in which `ready_i` is sampled high.
- R6: When `cfg_iwait_en` is 1, each cycle has at least `cfg_iwait_num` wait states, even with `ready_i` high. Each wait state adds 2 clocks.
- R7: When `cfg_adv_style` is 0, `addr_stb` is high for exactly the address clock of each cycle. When it is 1, `addr_stb` is low from the address clock until the end of the data phase, and high in the last clock of each cycle.
- R8: When `cfg_split_wr` is 0, `wr_lo_n` goes low during the data phase of every write. `wr_hi_n` goes low only when a 16-bit cycle writes the high lane, which means an odd byte address or a word.
- R9: When `cfg_split_wr` is 1, `wr_lo_n` goes low only for writes covering the even byte, and `wr_hi_n` only for writes covering the odd byte. A word on a 16-bit cycle covers both.
- R10: The data phase is clock 2 through the clock before last, plus any waits. Reads hold `rd_n` low for the data phase (2 clocks plus 2 per wait) with `ad_oe` low. Writes keep `ad_oe` high for the whole cycle and drive `req_wdata` for a 16-bit word, or the selected byte on both lanes otherwise.
- R11: `inst_o` is high in every clock of a read cycle whose request has `req_fetch` set. It is low for data reads and for writes.
- R12: A byte read returns `{8'h00, byte}`. The byte is taken from `ad_i[15:8]` on a 16-bit cycle at an odd address, and from `ad_i[7:0]` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pending |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Read is an instruction fetch |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| req_done | output | 1 | One-clock completion pulse |
| req_rdata | output | 16 | Read data, valid with `req_done` |
| cfg_dyn_width | input | 1 | Take the cycle width from `bus_width_i` |
| cfg_adv_style | input | 1 | 0 = latch pulse, 1 = address-valid level |
| cfg_split_wr | input | 1 | 0 = write + high enable, 1 = per-lane writes |
| cfg_iwait_en | input | 1 | Enable internal wait states |
| cfg_iwait_num | input | WAIT_W | Internal wait-state count |
| bus_width_i | input | 1 | External width select, 1 = 16-bit |
| ready_i | input | 1 | External ready |
| ad_i | input | 16 | Shared bus input |
| ad_o | output | 16 | Shared bus output value |
| ad_oe | output | 1 | Shared bus output enable |
| addr_stb | output | 1 | Address strobe (pulse or active-low level) |
| rd_n | output | 1 | Read strobe, active low |
| wr_lo_n | output | 1 | Write / low-lane write strobe, active low |
| wr_hi_n | output | 1 | High-enable / high-lane write strobe, active low |
| inst_o | output | 1 | Instruction-fetch indicator |

## Verification
The embedded assertions check several rules on every clock. Strobes and the bus enable stay quiet while idle, and the address phase lasts one clock. A cycle holds in the wait state while READY is low, and a pending internal count always forces a wait. The read strobe never overlaps a bus drive or a write strobe, the latch pulse is one clock wide, and the fetch indicator is stable within a cycle. The directed scenarios cover the rest. They measure exact cycle lengths with external and internal waits, and check the width decision and byte-cycle splitting. They also check lane selection of read data and write data, and which write strobe fires in each style.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_DAT1,
      PH_WAIT,
      PH_DAT2,
      PH_LAST
   } xbus_ph_e;

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int WAIT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              word_q,
   input  logic              cfg_dyn_width,
   input  logic              bus_width_i,
   input  logic              ready_i,
   input  logic              cfg_iwait_en,
   input  logic [WAIT_W-1:0] cfg_iwait_num,
   output xbus_ph_e          ph,
   output logic              wide,
   output logic              half,
   output logic              accept,
   output logic              done
);

   logic [WAIT_W-1:0] rem;
   logic [WAIT_W-1:0] rem_dec;
   logic [WAIT_W-1:0] rem_load;
   logic              wsub;
   logic              more;

   assign rem_dec  = (rem == '0) ? '0 : rem - 1'b1;
   assign rem_load = cfg_iwait_en ? cfg_iwait_num : '0;
   assign accept   = (ph == PH_IDLE) && req_valid;
   assign more     = word_q && !wide && !half;
   assign done     = (ph == PH_LAST) && !more;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph   <= PH_IDLE;
         wide <= 1'b0;
         half <= 1'b0;
         rem  <= '0;
         wsub <= 1'b0;
      end else begin
         unique case (ph)
            PH_IDLE: if (req_valid) begin
               ph   <= PH_ADDR;
               half <= 1'b0;
               rem  <= rem_load;
            end
            PH_ADDR: begin
               ph <= PH_DAT1;
               if (!half) wide <= cfg_dyn_width & bus_width_i;
            end
            PH_DAT1: begin
               wsub <= 1'b0;
               ph   <= (!ready_i || rem != '0) ? PH_WAIT : PH_DAT2;
            end
            PH_WAIT: begin
               wsub <= ~wsub;
               if (wsub) begin
                  rem <= rem_dec;
                  if (ready_i && rem_dec == '0) ph <= PH_DAT2;
               end
            end
            PH_DAT2: ph <= PH_LAST;
            PH_LAST: if (more) begin
               ph   <= PH_ADDR;
               half <= 1'b1;
               rem  <= rem_load;
            end else begin
               ph <= PH_IDLE;
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   // R2
   addr_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph == PH_ADDR |=> ph == PH_DAT1);

   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_IDLE && !req_valid) |=> ph == PH_IDLE);

   // R5
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_WAIT && !ready_i) |=> ph == PH_WAIT);

   // R6
   iwait_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_DAT1 && rem != '0) |=> ph == PH_WAIT);

endmodule

// File: rtl/xbus_lanes.sv
module xbus_lanes
   import xbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int AD_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  xbus_ph_e          ph,
   input  logic              wide,
   input  logic              half,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic              write_q,
   input  logic              fetch_q,
   input  logic              word_q,
   input  logic [AD_W-1:0]   wdata_q,
   input  logic              cfg_adv_style,
   input  logic              cfg_split_wr,
   input  logic [AD_W-1:0]   ad_i,
   output logic [AD_W-1:0]   ad_o,
   output logic              ad_oe,
   output logic              addr_stb,
   output logic              rd_n,
   output logic              wr_lo_n,
   output logic              wr_hi_n,
   output logic              inst_o,
   output logic [AD_W-1:0]   rdata
);

   localparam int BYTE_W = AD_W / 2;

   logic [ADDR_W-1:0] cyc_addr;
   logic              word16;
   logic              strobe_ph;
   logic              in_cyc;
   logic              wr_act;
   logic [1:0]        hit;
   logic [BYTE_W-1:0] wbyte;
   logic [BYTE_W-1:0] rbyte;

   assign cyc_addr  = addr_q + ADDR_W'(half);
   assign word16    = word_q & wide;
   assign in_cyc    = (ph != PH_IDLE);
   assign strobe_ph = (ph == PH_DAT1) || (ph == PH_WAIT) || (ph == PH_DAT2);
   assign wr_act    = strobe_ph && write_q;

   for (genvar l = 0; l < 2; l++) begin : g_lane
      assign hit[l] = word16 | (cyc_addr[0] == 1'(l));
   end

   assign wbyte = half ? wdata_q[AD_W-1:BYTE_W] : wdata_q[BYTE_W-1:0];
   assign rbyte = (wide && cyc_addr[0]) ? ad_i[AD_W-1:BYTE_W] : ad_i[BYTE_W-1:0];

   always_comb begin
      if (ph == PH_ADDR)  ad_o = AD_W'(cyc_addr);
      else if (word16)    ad_o = wdata_q;
      else                ad_o = {wbyte, wbyte};
   end

   assign ad_oe    = (ph == PH_ADDR) || (write_q && in_cyc);
   assign rd_n     = !(strobe_ph && !write_q);
   assign wr_lo_n  = !(wr_act && (cfg_split_wr ? hit[0] : 1'b1));
   assign wr_hi_n  = !(wr_act && (cfg_split_wr ? hit[1] : (wide && hit[1])));
   assign addr_stb = cfg_adv_style ? !((ph == PH_ADDR) || strobe_ph) : (ph == PH_ADDR);
   assign inst_o   = in_cyc && fetch_q && !write_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (ph == PH_DAT2 && !write_q) begin
         if (word16)    rdata <= ad_i;
         else if (half) rdata[AD_W-1:BYTE_W] <= rbyte;
         else           rdata <= {{BYTE_W{1'b0}}, rbyte};
      end
   end

   // R10
   rd_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_oe);

   // R8
   rd_wr_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> (wr_lo_n && wr_hi_n));

   // R7
   latch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_adv_style && addr_stb) |=> !addr_stb);

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
   import xbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int WAIT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_fetch,
   input  logic              req_word,
   input  logic [15:0]       req_wdata,
   output logic              req_done,
   output logic [15:0]       req_rdata,
   input  logic              cfg_dyn_width,
   input  logic              cfg_adv_style,
   input  logic              cfg_split_wr,
   input  logic              cfg_iwait_en,
   input  logic [WAIT_W-1:0] cfg_iwait_num,
   input  logic              bus_width_i,
   input  logic              ready_i,
   input  logic [15:0]       ad_i,
   output logic [15:0]       ad_o,
   output logic              ad_oe,
   output logic              addr_stb,
   output logic              rd_n,
   output logic              wr_lo_n,
   output logic              wr_hi_n,
   output logic              inst_o
);

   localparam int AD_W = 16;

   if (ADDR_W < 2 || ADDR_W > AD_W) begin : g_bad_addr
      $error("xbus_ctrl: ADDR_W must lie in 2..16");
   end
   if (WAIT_W < 1 || WAIT_W > 8) begin : g_bad_wait
      $error("xbus_ctrl: WAIT_W must lie in 1..8");
   end

   xbus_ph_e          ph;
   logic              wide;
   logic              half;
   logic              accept;
   logic [ADDR_W-1:0] addr_q;
   logic              write_q;
   logic              fetch_q;
   logic              word_q;
   logic [AD_W-1:0]   wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         write_q <= 1'b0;
         fetch_q <= 1'b0;
         word_q  <= 1'b0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         write_q <= req_write;
         fetch_q <= req_fetch;
         word_q  <= req_word;
         wdata_q <= req_wdata;
      end
   end

   xbus_seq #(.WAIT_W(WAIT_W)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .word_q        (word_q),
      .cfg_dyn_width (cfg_dyn_width),
      .bus_width_i   (bus_width_i),
      .ready_i       (ready_i),
      .cfg_iwait_en  (cfg_iwait_en),
      .cfg_iwait_num (cfg_iwait_num),
      .ph            (ph),
      .wide          (wide),
      .half          (half),
      .accept        (accept),
      .done          (req_done)
   );

   xbus_lanes #(.ADDR_W(ADDR_W), .AD_W(AD_W)) u_lanes (
      .clk           (clk),
      .rst_n         (rst_n),
      .ph            (ph),
      .wide          (wide),
      .half          (half),
      .addr_q        (addr_q),
      .write_q       (write_q),
      .fetch_q       (fetch_q),
      .word_q        (word_q),
      .wdata_q       (wdata_q),
      .cfg_adv_style (cfg_adv_style),
      .cfg_split_wr  (cfg_split_wr),
      .ad_i          (ad_i),
      .ad_o          (ad_o),
      .ad_oe         (ad_oe),
      .addr_stb      (addr_stb),
      .rd_n          (rd_n),
      .wr_lo_n       (wr_lo_n),
      .wr_hi_n       (wr_hi_n),
      .inst_o        (inst_o),
      .rdata         (req_rdata)
   );

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph == PH_IDLE |-> (rd_n && wr_lo_n && wr_hi_n && !ad_oe && !inst_o));

   // R11
   inst_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_DAT1 || ph == PH_WAIT || ph == PH_DAT2 || ph == PH_LAST) |-> $stable(inst_o));

endmodule

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        req_fetch = 1'b0;
   logic        req_word = 1'b0;
   logic [15:0] req_wdata = '0;
   logic        req_done;
   logic [15:0] req_rdata;
   logic        cfg_dyn_width = 1'b1;
   logic        cfg_adv_style = 1'b0;
   logic        cfg_split_wr = 1'b0;
   logic        cfg_iwait_en = 1'b0;
   logic [1:0]  cfg_iwait_num = 2'd0;
   logic        bus_width_i = 1'b1;
   logic        ready_i = 1'b1;
   logic [15:0] ad_i;
   logic [15:0] ad_o;
   logic        ad_oe, addr_stb, rd_n, wr_lo_n, wr_hi_n, inst_o;

   xbus_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_fetch(req_fetch), .req_word(req_word),
      .req_wdata(req_wdata), .req_done(req_done), .req_rdata(req_rdata),
      .cfg_dyn_width(cfg_dyn_width), .cfg_adv_style(cfg_adv_style),
      .cfg_split_wr(cfg_split_wr), .cfg_iwait_en(cfg_iwait_en),
      .cfg_iwait_num(cfg_iwait_num), .bus_width_i(bus_width_i),
      .ready_i(ready_i), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
      .addr_stb(addr_stb), .rd_n(rd_n), .wr_lo_n(wr_lo_n),
      .wr_hi_n(wr_hi_n), .inst_o(inst_o)
   );

   always #10 clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   int wd_cnt  = 0;

   // external memory model: byte at address a
   function automatic logic [7:0] mb(input logic [15:0] a);
      return a[7:0] ^ 8'h3C;
   endfunction

   logic [15:0] lat_a = '0;
   logic        lprev = 1'b0;
   always @(negedge clk) begin
      if (cfg_adv_style ? (!addr_stb && lprev) : addr_stb) lat_a <= ad_o;
      lprev <= addr_stb;
   end
   assign ad_i = (bus_width_i && cfg_dyn_width) ? {mb(lat_a | 16'h1), mb(lat_a & 16'hFFFE)}
                                                : {8'hEE, mb(lat_a)};

   always @(posedge clk) begin
      wd_cnt <= wd_cnt + 1;
      if (wd_cnt == 100000) begin
         n_tests = n_tests + 1;
         n_fail  = n_fail + 1;
         $display("FAIL watchdog: got %0d cycles expected fewer", wd_cnt);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_tests = n_tests + 1;
      if (act != exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
      end
   endtask

   int n_clk, n_stb_hi, n_stb_lo, n_rd, n_rdoe, n_wl, n_wh, n_wroe, n_inst, n_lat, n_wseen;
   logic [15:0] lat_first, lat_last, wd_first, wd_last;
   logic        tprev;

   task automatic sample();
      n_clk++;
      if (addr_stb) n_stb_hi++; else n_stb_lo++;
      if (!rd_n) n_rd++;
      if (!rd_n && ad_oe) n_rdoe++;
      if (!wr_lo_n) n_wl++;
      if (!wr_hi_n) n_wh++;
      if (!wr_lo_n || !wr_hi_n) begin
         if (!ad_oe) n_wroe++;
         if (n_wseen == 0) wd_first = ad_o;
         wd_last = ad_o;
         n_wseen++;
      end
      if (inst_o) n_inst++;
      if (cfg_adv_style ? (!addr_stb && tprev) : addr_stb) begin
         if (n_lat == 0) lat_first = ad_o;
         lat_last = ad_o;
         n_lat++;
      end
      tprev = addr_stb;
   endtask

   task automatic run(input logic [15:0] a, input bit wr, input bit f, input bit w,
                      input logic [15:0] wd, input int ready_at);
      @(negedge clk);
      n_clk = 0; n_stb_hi = 0; n_stb_lo = 0; n_rd = 0; n_rdoe = 0; n_wl = 0;
      n_wh = 0; n_wroe = 0; n_inst = 0; n_lat = 0; n_wseen = 0;
      tprev = addr_stb;
      req_addr = a; req_write = wr; req_fetch = f; req_word = w; req_wdata = wd;
      if (ready_at > 0) ready_i = 1'b0;
      req_valid = 1'b1;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         sample();
         if (ready_at == n_clk) ready_i = 1'b1;
         if (req_done) break;
      end
      req_valid = 1'b0;
      ready_i = 1'b1;
   endtask

   task automatic t_reset();
      chk("R1 reset rd_n", rd_n, 1);
      chk("R1 reset wr_lo_n", wr_lo_n, 1);
      chk("R1 reset wr_hi_n", wr_hi_n, 1);
      chk("R1 reset ad_oe", ad_oe, 0);
      chk("R1 reset inst_o", inst_o, 0);
      chk("R1 reset addr_stb", addr_stb, 0);
   endtask

   task automatic t_idle_inputs();
      int bad = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         ready_i = ~ready_i;
         bus_width_i = ~bus_width_i;
         @(negedge clk);
         if (!rd_n || !wr_lo_n || !wr_hi_n || ad_oe || inst_o || req_done || addr_stb) bad++;
      end
      ready_i = 1'b1; bus_width_i = 1'b1;
      chk("R1 idle toggles ignored", bad, 0);
   endtask

   task automatic t_byte_read16();
      cfg_dyn_width = 1'b1; bus_width_i = 1'b1;
      run(16'h1235, 0, 0, 0, 16'h0, 0);
      chk("R2 base cycle clocks", n_clk, 4);
      chk("R2 address on bus", lat_first, 16'h1235);
      chk("R12 odd byte from high lane", req_rdata, {8'h00, mb(16'h1235)});
      chk("R10 rd_n low clocks", n_rd, 2);
      chk("R10 bus released while reading", n_rdoe, 0);
      chk("R11 data read inst low", n_inst, 0);
      chk("R7 latch pulse width", n_stb_hi, 1);
   endtask

   task automatic t_word_fetch16();
      run(16'h2000, 0, 1, 1, 16'h0, 0);
      chk("R3 wide word clocks", n_clk, 4);
      chk("R3 wide word data", req_rdata, {mb(16'h2001), mb(16'h2000)});
      chk("R11 fetch inst high every clock", n_inst, 4);
   endtask

   task automatic t_width_off();
      cfg_dyn_width = 1'b0; bus_width_i = 1'b1;
      run(16'h3010, 0, 0, 1, 16'h0, 0);
      chk("R3 fixed 8-bit splits word clocks", n_clk, 8);
      chk("R4 two address phases", n_lat, 2);
      chk("R4 first address", lat_first, 16'h3010);
      chk("R4 second address", lat_last, 16'h3011);
      chk("R4 assembled word", req_rdata, {mb(16'h3011), mb(16'h3010)});
      run(16'h6003, 0, 0, 0, 16'h0, 0);
      chk("R12 narrow byte from low lane", req_rdata, {8'h00, mb(16'h6003)});
      cfg_dyn_width = 1'b1;
   endtask

   task automatic t_pin_narrow();
      bus_width_i = 1'b0;
      run(16'h0440, 0, 0, 1, 16'h0, 0);
      chk("R3 pin low gives 8-bit cycles", n_clk, 8);
      bus_width_i = 1'b1;
   endtask

   task automatic t_ready();
      run(16'h0102, 0, 0, 0, 16'h0, 5);
      chk("R5 two ready waits clocks", n_clk, 8);
      chk("R5 rd_n stretched", n_rd, 6);
      run(16'h0104, 0, 0, 0, 16'h0, 3);
      chk("R5 one ready wait clocks", n_clk, 6);
   endtask

   task automatic t_iwait();
      cfg_iwait_en = 1'b1; cfg_iwait_num = 2'd3;
      run(16'h0200, 0, 0, 0, 16'h0, 0);
      chk("R6 three internal waits", n_clk, 10);
      cfg_iwait_num = 2'd0;
      run(16'h0200, 0, 0, 0, 16'h0, 0);
      chk("R6 zero internal waits", n_clk, 4);
      cfg_iwait_en = 1'b0; cfg_iwait_num = 2'd2;
      run(16'h0200, 0, 0, 0, 16'h0, 0);
      chk("R6 count ignored when disabled", n_clk, 4);
      cfg_iwait_num = 2'd0;
   endtask

   task automatic t_adv();
      cfg_adv_style = 1'b1;
      @(negedge clk);
      chk("R1 idle level style high", addr_stb, 1);
      run(16'h0306, 0, 0, 0, 16'h0, 0);
      chk("R7 level style low clocks", n_stb_lo, 3);
      chk("R7 level style address", lat_first, 16'h0306);
      cfg_dyn_width = 1'b0;
      run(16'h0308, 0, 0, 1, 16'h0, 0);
      chk("R7 level style high between halves", n_stb_lo, 6);
      cfg_dyn_width = 1'b1; cfg_adv_style = 1'b0;
   endtask

   task automatic t_write_comb();
      cfg_split_wr = 1'b0;
      run(16'h4001, 1, 1, 0, 16'h00A7, 0);
      chk("R8 write strobe on odd byte", n_wl, 2);
      chk("R8 high enable on odd byte", n_wh, 2);
      chk("R10 byte on both lanes", wd_first, 16'hA7A7);
      chk("R10 bus driven through write", n_wroe, 0);
      chk("R11 inst low on write", n_inst, 0);
      run(16'h4002, 1, 0, 0, 16'h0033, 0);
      chk("R8 no high enable on even byte", n_wh, 0);
      cfg_dyn_width = 1'b0;
      run(16'h5000, 1, 0, 1, 16'h1234, 0);
      chk("R8 narrow word write strobes", n_wl, 4);
      chk("R8 no high enable on 8-bit", n_wh, 0);
      chk("R4 low byte written first", wd_first[7:0], 8'h34);
      chk("R4 high byte written second", wd_last[7:0], 8'h12);
      cfg_dyn_width = 1'b1;
   endtask

   task automatic t_write_split();
      cfg_split_wr = 1'b1;
      run(16'h4011, 1, 0, 0, 16'h005A, 0);
      chk("R9 odd byte no low strobe", n_wl, 0);
      chk("R9 odd byte high strobe", n_wh, 2);
      run(16'h4010, 1, 0, 0, 16'h005A, 0);
      chk("R9 even byte low strobe", n_wl, 2);
      chk("R9 even byte no high strobe", n_wh, 0);
      run(16'h4004, 1, 0, 1, 16'hBEEF, 0);
      chk("R9 word both strobes", n_wl + n_wh, 4);
      chk("R10 word data on bus", wd_first, 16'hBEEF);
      cfg_split_wr = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_idle_inputs();
      t_byte_read16();
      t_word_fetch16();
      t_width_off();
      t_pin_narrow();
      t_ready();
      t_iwait();
      t_adv();
      t_write_comb();
      t_write_split();
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule